// File: doc/BRIEF.md
# Clock Source Switch Controller

This block chooses where the system clock comes from: an always-running internal RC oscillator or an external crystal or oscillator. Before the external source may be used it must complete a warmup of a fixed number of its own cycles. The count runs in the external clock domain, and the ready indication is then synchronised into the RC domain. The hand-over between the two sources goes through a two-sided gating handshake, so the output clock never shows a shortened high or low phase.

Software drives two control bits through a single-cycle write strobe. The first is an oscillator-enable that powers the external source. The second is a source-select that asks for the external clock. There are two ways to use them. In the first, software sets only the source-select; the block powers the oscillator, waits for warmup and switches on its own, and software polls the RC-mode flag to see the change. In the second, software sets the enable, waits for the ready flag or its interrupt, and then sets the source-select, which switches at once. Clearing the source-select always returns to RC within a few cycles. If the enable stays set, the oscillator keeps running and keeps its ready state.

Top module: `clksw_top`

## Requirements
- R1: After reset, rc_mode is 1, and osc_en, src_sel, osc_run, xtal_rdy, irq and irq_pend are all 0. sys_clk follows clk_rc.
- R2: xtal_rdy rises only after WARMUP_CYCLES (default 65536) rising edges of clk_ext, counted from the moment osc_run goes high. It appears no later than eight further clk_ext edges after that.
- R3: With xtal_rdy already 1, a write of src_sel=1 clears rc_mode within 6 clk_rc cycles. sys_clk then runs at the clk_ext period.
- R4: With osc_en=0, a write of src_sel=1 raises osc_run while the warmup is still in progress. rc_mode stays 1 until xtal_rdy is 1, and rc_mode never falls in a cycle that follows a cycle with xtal_rdy=0.
- R5: A write of src_sel=0 sets rc_mode within 6 clk_rc cycles, with no warmup. sys_clk then runs at the clk_rc period.
- R6: While osc_en stays 1, returning to RC leaves osc_run and xtal_rdy at 1. A later src_sel=1 switches within 6 cycles.
- R7: Once osc_en=0 and src_sel=0 and rc_mode is 1, osc_run drops and xtal_rdy is 0 from the third cycle of osc_run low onwards. The next use needs a full warmup again.
- R8: Every high and every low phase of sys_clk lasts at least the shorter half-period of the two sources. The two gates are never open together.
- R9: irq is a one-cycle pulse, high in the cycle after xtal_rdy is first seen high. irq_pend is set in that same cycle.
- R10: A write with wr_irq_ack=1 clears irq_pend on the next cycle. If the set and the acknowledge fall in the same cycle, the set wins.
- R11: osc_run equals (osc_en | src_sel | !rc_mode), delayed by one clk_rc cycle. osc_en and src_sel read back the last written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC oscillator clock; also clocks the control logic |
| clk_ext | input | 1 | External crystal or oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control bits |
| wr_osc_en | input | 1 | Oscillator-enable value to write |
| wr_src_sel | input | 1 | Source-select value to write (1 = external) |
| wr_irq_ack | input | 1 | Writing 1 clears the pending ready interrupt |
| osc_en | output | 1 | Readback of oscillator-enable |
| src_sel | output | 1 | Readback of source-select |
| osc_run | output | 1 | Power request to the external oscillator |
| xtal_rdy | output | 1 | Warmup complete, synchronised to clk_rc |
| rc_mode | output | 1 | 1 while the system clock is taken from RC |
| irq | output | 1 | One-cycle ready interrupt request |
| irq_pend | output | 1 | Pending flag of the ready interrupt |
| sys_clk | output | 1 | Selected, glitch-free system clock |

## Verification
The bench counts external edges from the moment the oscillator is powered. An off-by-one or truncated warmup counter therefore shows up as a ready flag that rises outside its window. A design that stopped the oscillator before its gate closed would deadlock the handshake and would never set rc_mode again. A mux that gated at the wrong phase would produce a short sys_clk pulse, and pulse-width timing catches that. The acknowledge is timed to land on the same edge as the interrupt set, so a design that lets the clear win loses the interrupt. After a disable, a second full-length warmup is required, so a design that kept the old count would report ready too soon.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

   typedef enum logic {
      SRC_RC  = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int STAGES    = 2,
   parameter bit RST_VAL   = 1'b0,
   parameter bit FALL_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] st;

   if (STAGES < 2) begin : g_bad_depth
      $error("clksw_sync needs at least two stages");
   end

   if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) st <= {STAGES{RST_VAL}};
         else        st <= {st[STAGES-2:0], d};
      end
   end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= {STAGES{RST_VAL}};
         else        st <= {st[STAGES-2:0], d};
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/clksw_warmup.sv
`timescale 1ns/1ps
module clksw_warmup #(
   parameter int WARMUP_CYCLES = 65536,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_ext,
   input  logic xrst_n,
   output logic rdy_x
);

   localparam int CW = clksw_pkg::cnt_width(WARMUP_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(WARMUP_CYCLES - 1);

   logic          en_x;
   logic [CW-1:0] cnt;

   // release of the oscillator power request, seen on the external clock
   clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_en_sync (
      .clk   (clk_ext),
      .rst_n (xrst_n),
      .d     (1'b1),
      .q     (en_x)
   );

   always_ff @(posedge clk_ext or negedge xrst_n) begin
      if (!xrst_n) begin
         cnt   <= '0;
         rdy_x <= 1'b0;
      end else if (en_x && !rdy_x) begin
         if (cnt == LAST) rdy_x <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

   // R2
   warm_full_count_chk: assert property (@(posedge clk_ext) disable iff (!xrst_n)
      $rose(rdy_x) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/clksw_gmux.sv
`timescale 1ns/1ps
module clksw_gmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_rc,
   input  logic clk_ext,
   input  logic rst_n,
   input  logic sel_ext,
   output logic sys_clk,
   output logic rc_on,
   output logic ext_on
);

   logic rc_req;
   logic ext_req;

   // a side may open only after the other side is seen closed
   assign rc_req  = !sel_ext && !ext_on;
   assign ext_req =  sel_ext && !rc_on;

   clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALL_EDGE(1'b1)) u_rc_gate (
      .clk   (clk_rc),
      .rst_n (rst_n),
      .d     (rc_req),
      .q     (rc_on)
   );

   clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_EDGE(1'b1)) u_ext_gate (
      .clk   (clk_ext),
      .rst_n (rst_n),
      .d     (ext_req),
      .q     (ext_on)
   );

   assign sys_clk = (clk_rc & rc_on) | (clk_ext & ext_on);

   // R8
   gates_excl_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      !(rc_on && ext_on));

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top #(
   parameter int WARMUP_CYCLES = 65536,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk_rc,
   input  logic clk_ext,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_osc_en,
   input  logic wr_src_sel,
   input  logic wr_irq_ack,
   output logic osc_en,
   output logic src_sel,
   output logic osc_run,
   output logic xtal_rdy,
   output logic rc_mode,
   output logic irq,
   output logic irq_pend,
   output logic sys_clk
);
   import clksw_pkg::*;

   if (WARMUP_CYCLES < 4) begin : g_bad_warm
      $error("WARMUP_CYCLES must be at least 4");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_bad_sync
      $error("SYNC_STAGES must lie between 2 and 8");
   end

   logic     xten_q, xsel_q, run_q;
   logic     xrst_n, rdy_x, rdy_s, rdy_d;
   logic     rc_on, ext_on, mode_q;
   logic     irq_q, pend_q, rdy_edge;
   clk_src_e want_src;
   logic [3:0] low_cnt;

   always_ff @(posedge clk_rc or negedge rst_n) begin
      if (!rst_n) begin
         xten_q <= 1'b0;
         xsel_q <= 1'b0;
      end else if (wr_en) begin
         xten_q <= wr_osc_en;
         xsel_q <= wr_src_sel;
      end
   end

   // keep the oscillator alive until its gate has closed
   always_ff @(posedge clk_rc or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= xten_q | xsel_q | !mode_q;
   end

   assign xrst_n = rst_n & run_q;

   clksw_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_warm (
      .clk_ext (clk_ext),
      .xrst_n  (xrst_n),
      .rdy_x   (rdy_x)
   );

   clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_EDGE(1'b0)) u_rdy_sync (
      .clk   (clk_rc),
      .rst_n (rst_n),
      .d     (rdy_x),
      .q     (rdy_s)
   );

   assign want_src = clk_src_e'(xsel_q & rdy_s);

   clksw_gmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .clk_rc  (clk_rc),
      .clk_ext (clk_ext),
      .rst_n   (rst_n),
      .sel_ext (want_src == SRC_EXT),
      .sys_clk (sys_clk),
      .rc_on   (rc_on),
      .ext_on  (ext_on)
   );

   assign rdy_edge = rdy_s & !rdy_d;

   always_ff @(posedge clk_rc or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b1;
         rdy_d  <= 1'b0;
         irq_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         mode_q <= rc_on;
         rdy_d  <= rdy_s;
         irq_q  <= rdy_edge;
         if (rdy_edge)                 pend_q <= 1'b1;
         else if (wr_en && wr_irq_ack) pend_q <= 1'b0;
      end
   end

   assign osc_en   = xten_q;
   assign src_sel  = xsel_q;
   assign osc_run  = run_q;
   assign xtal_rdy = rdy_s;
   assign rc_mode  = mode_q;
   assign irq      = irq_q;
   assign irq_pend = pend_q;

   // cycles the power request has been low, for the ready-clear window
   always_ff @(posedge clk_rc or negedge rst_n) begin
      if (!rst_n)            low_cnt <= '0;
      else if (run_q)        low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
   end

   // R9
   irq_single_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      irq |=> !irq);
   // R9
   irq_sets_pend_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      irq |-> irq_pend);
   // R10
   ack_clears_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      (wr_en && wr_irq_ack && !(xtal_rdy && !rdy_d)) |=> !irq_pend);
   // R4
   switch_needs_rdy_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      $fell(rc_mode) |-> $past(xtal_rdy));
   // R7
   rdy_drops_chk: assert property (@(posedge clk_rc) disable iff (!rst_n)
      (low_cnt >= 4'(SYNC_STAGES)) |-> !xtal_rdy);

endmodule

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;

   localparam int WARM = 65536;

   logic clk_rc = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_osc_en = 1'b0, wr_src_sel = 1'b0, wr_irq_ack = 1'b0;
   logic osc_en, src_sel, osc_run, xtal_rdy, rc_mode, irq, irq_pend, sys_clk;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   clksw_top #(.WARMUP_CYCLES(WARM), .SYNC_STAGES(2)) dut_i (
      .clk_rc, .clk_ext, .rst_n, .wr_en, .wr_osc_en, .wr_src_sel, .wr_irq_ack,
      .osc_en, .src_sel, .osc_run, .xtal_rdy, .rc_mode, .irq, .irq_pend, .sys_clk
   );

   // 200 MHz RC clock
   always #2.5 clk_rc = ~clk_rc;

   // external oscillator: about 333 MHz, runs only while powered, stops low
   initial begin
      #0.7;
      forever begin
         #1.5;
         if (osc_run || clk_ext) clk_ext = ~clk_ext;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // external edges since power-up
   int ext_cnt = 0;
   always @(posedge clk_ext or negedge osc_run) begin
      if (!osc_run) ext_cnt = 0;
      else          ext_cnt = ext_cnt + 1;
   end

   // pulse widths of sys_clk
   realtime t_edge = 0.0;
   always @(sys_clk) begin
      if (rst_n && t_edge > 0.0)
         chk(($realtime - t_edge) >= 1.49, "R8", "sys_clk phase ps",
             longint'(($realtime - t_edge) * 1000.0), 1500);
      t_edge = $realtime;
   end

   // reference model, compared every RC cycle
   bit m_xten = 0, m_xsel = 0, m_pend = 0;
   bit p_rdy1 = 0, p_rdy2 = 0, p_mode = 1;
   int mis_cnt = 0, low_b = 0;
   always @(negedge clk_rc) begin
      if (rst_n && !done) begin
         bit e_irq, e_pend, e_osc, target;
         e_irq  = p_rdy1 && !p_rdy2;
         e_pend = e_irq ? 1'b1 : ((wr_en && wr_irq_ack) ? 1'b0 : m_pend);
         e_osc  = m_xten || m_xsel || !p_mode;
         if (wr_en) begin
            m_xten = wr_osc_en;
            m_xsel = wr_src_sel;
         end
         chk(osc_en == m_xten, "R11", "osc_en", osc_en, m_xten);
         chk(src_sel == m_xsel, "R11", "src_sel", src_sel, m_xsel);
         chk(osc_run == e_osc, "R11", "osc_run", osc_run, e_osc);
         chk(irq == e_irq, "R9", "irq", irq, e_irq);
         chk(irq_pend == e_pend, "R10", "irq_pend", irq_pend, e_pend);
         m_pend = e_pend;
         // ready window
         if (xtal_rdy && !p_rdy1)
            chk(ext_cnt >= WARM + 2, "R2", "ready too early at ext edge", ext_cnt, WARM + 2);
         if (osc_run && !xtal_rdy)
            chk(ext_cnt <= WARM + 8, "R2", "ready late at ext edge", ext_cnt, WARM + 8);
         low_b = osc_run ? 0 : low_b + 1;
         if (low_b >= 3)
            chk(!xtal_rdy, "R7", "xtal_rdy after power off", xtal_rdy, 0);
         // source tracking
         if (p_mode && !rc_mode)
            chk(p_rdy1, "R4", "rc_mode fell without ready", p_rdy1, 1);
         target = !(m_xsel && xtal_rdy);
         mis_cnt = (rc_mode != target) ? mis_cnt + 1 : 0;
         chk(mis_cnt <= 8, "R3", "rc_mode stuck away from target", rc_mode, target);
         p_rdy2 = p_rdy1;
         p_rdy1 = xtal_rdy;
         p_mode = rc_mode;
      end
   end

   task automatic write_now(input bit en, input bit sel, input bit ack);
      #1;
      wr_en = 1'b1; wr_osc_en = en; wr_src_sel = sel; wr_irq_ack = ack;
      @(negedge clk_rc);
      #1;
      wr_en = 1'b0; wr_irq_ack = 1'b0;
   endtask

   task automatic write(input bit en, input bit sel, input bit ack);
      @(negedge clk_rc);
      write_now(en, sel, ack);
   endtask

   task automatic wait_rdy(output int cyc);
      cyc = 0;
      while (!xtal_rdy && cyc < 60000) begin
         @(negedge clk_rc);
         cyc++;
      end
   endtask

   task automatic cycles_until_mode(input bit val, output int cyc);
      cyc = 0;
      while (rc_mode != val && cyc < 20) begin
         @(negedge clk_rc);
         cyc++;
      end
   endtask

   task automatic sys_period(output longint ps);
      realtime t0;
      @(posedge sys_clk);
      t0 = $realtime;
      @(posedge sys_clk);
      ps = longint'(($realtime - t0) * 1000.0);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (190000) @(posedge clk_rc);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      int cyc;
      longint per;
      repeat (3) @(negedge clk_rc);
      #1 rst_n = 1'b1;
      @(negedge clk_rc);
      // R1 reset state
      chk(rc_mode == 1'b1, "R1", "rc_mode", rc_mode, 1);
      chk({osc_en, src_sel, osc_run, xtal_rdy, irq, irq_pend} == 6'b0, "R1", "status",
          {osc_en, src_sel, osc_run, xtal_rdy, irq, irq_pend}, 0);
      sys_period(per);
      chk(per == 5000, "R1", "sys_clk period ps", per, 5000);

      // manual method
      write(1'b1, 1'b0, 1'b0);
      repeat (3) @(negedge clk_rc);
      chk(osc_run, "R11", "osc_run after enable", osc_run, 1);
      wait_rdy(cyc);
      chk(xtal_rdy, "R2", "manual warmup done", xtal_rdy, 1);
      repeat (4) @(negedge clk_rc);
      chk(irq_pend, "R9", "pend after ready", irq_pend, 1);
      chk(rc_mode, "R3", "still on RC before select", rc_mode, 1);
      write(1'b1, 1'b1, 1'b0);
      cycles_until_mode(1'b0, cyc);
      chk(cyc <= 6, "R3", "cycles to switch", cyc, 6);
      repeat (4) @(negedge clk_rc);
      sys_period(per);
      chk(per == 3000, "R3", "sys_clk period ps", per, 3000);

      // acknowledge
      write(1'b1, 1'b1, 1'b1);
      chk(!irq_pend, "R10", "pend after ack", irq_pend, 0);

      // back to RC keeping the oscillator on
      write(1'b1, 1'b0, 1'b0);
      cycles_until_mode(1'b1, cyc);
      chk(cyc <= 6, "R5", "cycles back to RC", cyc, 6);
      repeat (4) @(negedge clk_rc);
      sys_period(per);
      chk(per == 5000, "R5", "sys_clk period ps", per, 5000);
      chk(xtal_rdy && osc_run, "R6", "ready kept", {xtal_rdy, osc_run}, 3);
      write(1'b1, 1'b1, 1'b0);
      cycles_until_mode(1'b0, cyc);
      chk(cyc <= 6, "R6", "immediate reselect", cyc, 6);
      repeat (4) @(negedge clk_rc);

      // full release
      write(1'b0, 1'b0, 1'b0);
      cycles_until_mode(1'b1, cyc);
      chk(cyc <= 6, "R5", "cycles back to RC", cyc, 6);
      repeat (8) @(negedge clk_rc);
      chk(!osc_run && !xtal_rdy, "R7", "power off clears ready", {osc_run, xtal_rdy}, 0);

      // automatic method, acknowledge colliding with the set
      write(1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk_rc);
      chk(osc_run && rc_mode, "R4", "powered while on RC", {osc_run, rc_mode}, 3);
      wait_rdy(cyc);
      chk(cyc >= 39300, "R7", "full warmup cycles", cyc, 39300);
      write_now(1'b0, 1'b1, 1'b1);
      chk(irq_pend, "R10", "set wins over ack", irq_pend, 1);
      cycles_until_mode(1'b0, cyc);
      chk(!rc_mode, "R4", "auto switch", rc_mode, 0);
      repeat (4) @(negedge clk_rc);
      sys_period(per);
      chk(per == 3000, "R4", "sys_clk period ps", per, 3000);

      write(1'b0, 1'b0, 1'b1);
      cycles_until_mode(1'b1, cyc);
      chk(cyc <= 6, "R5", "cycles back to RC", cyc, 6);
      repeat (8) @(negedge clk_rc);
      chk(!osc_run && !irq_pend, "R7", "off and acked", {osc_run, irq_pend}, 0);

      done = 1'b1;
      report();
      $finish;
   end

endmodule